// File: doc/BRIEF.md
# Programmable Raster Scan Timing Generator

This block derives the raster timing for a display transmitter from a small bank of 32-bit configuration words. It runs on the pixel clock. A horizontal counter walks each line and a vertical counter walks each field. The block decodes the two counters into horizontal sync, vertical sync, a data-valid strobe, and the column and row of the pixel currently inside the visible window. The encoder, the serializer and the clock source sit downstream and are outside this block.

Software writes the configuration over a single-cycle write port. The words land in a shadow bank at any time. While scanning, the shadow bank is copied into the working bank only at the end of a complete frame, so a frame never mixes two timings. While output is disabled, the working bank follows the shadow bank, the counters rest at zero and both syncs sit at their idle level. The block supports progressive and interlaced scanning, a double-clocked pixel mode, and a choice of sync polarity for each sync.

Top module: `scan_timing_gen`

## Requirements
- R1: Every timing field holds its count minus one. Word address 1 holds the visible size, address 2 the back porch, address 3 the front porch and address 4 the sync width. In each of these words the vertical field sits in bits 31:16 and the horizontal field in bits 15:0. A line lasts A+F+B pixel clocks, where A, F and B are the decoded visible, front-porch and back-porch counts, and the visible pixels come first.
- R2: Horizontal sync is active for S clocks, starting at clock A+F of the line. The back-porch count B runs from the start of sync to the end of the line, so the sync pulse lies inside it.
- R3: A progressive frame has Va+Fv+Bv lines. Vertical sync is active from the start of line Va+Fv for Sv whole lines. After the last clock of a frame the counters return to pixel 0 of line 0.
- R4: The data-valid strobe is high only when the pixel lies inside both the horizontal and the vertical visible ranges. It is then accompanied by the column and row inside the visible window. Both positions read 0 while the strobe is low.
- R5: When bit 0 of the control word (address 0) is set, the horizontal counts are taken as already doubled and the reported column advances once every two clocks, so each pixel is held for two clocks.
- R6: When bit 4 of the control word is set, a frame consists of two fields. Each field has Va/2 visible lines and Va/2+Fv+Bv lines in total. The field output is 0 for the first field and 1 for the second, and the reported row is twice the field line plus the field number.
- R7: In the second interlaced field, vertical sync starts and ends half a line (the integer half of the line length in clocks) later than in the first field.
- R8: In the polarity word (address 5), bit 1 set makes vertical sync active high and bit 0 set makes horizontal sync active high. A clear bit makes that sync active low.
- R9: When bit 31 of the control word is clear, the counters are held at zero, the strobe, positions and field output are 0, and each sync sits at its inactive level. After that bit is set, scanning starts from pixel 0 of line 0 of the first field with the timing written before it.
- R10: A write to the timing, polarity or mode fields while scanning changes nothing until the current frame ends. From the first clock of the next frame onward the new values apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, one word per cycle |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| de | output | 1 | Visible-pixel strobe |
| px_x | output | 16 | Column within the visible window |
| px_y | output | 16 | Row within the visible window |
| field_id | output | 1 | Current interlaced field |

## Verification
Two functions can fall in one cycle: a configuration write reaching the shadow bank, and the frame wrap that copies the shadow bank into the working bank. The bench provokes the first alone by rewriting the visible width in the middle of a running frame. It then compares every pixel clock against an arithmetic model that keeps the old width until the exact frame boundary and uses the new width from the following clock. The interlaced sweep also makes the half-line vertical sync boundary coincide with visible-row bookkeeping across the field change, and every cycle of both fields is judged against the same model.

// File: rtl/stg_pkg.sv
package stg_pkg;

    localparam int STG_FW = 16;

    localparam int ADR_CTRL = 0;
    localparam int ADR_SIZE = 1;
    localparam int ADR_BACK = 2;
    localparam int ADR_FRONT = 3;
    localparam int ADR_SYNC = 4;
    localparam int ADR_POL = 5;

    localparam int BIT_RUN = 31;
    localparam int BIT_ILACE = 4;
    localparam int BIT_DOUBLE = 0;
    localparam int BIT_VPOL = 1;
    localparam int BIT_HPOL = 0;

    typedef struct packed {
        logic [STG_FW-1:0] ha;
        logic [STG_FW-1:0] hf;
        logic [STG_FW-1:0] hs;
        logic [STG_FW-1:0] hb;
        logic [STG_FW-1:0] va;
        logic [STG_FW-1:0] vf;
        logic [STG_FW-1:0] vs;
        logic [STG_FW-1:0] vb;
        logic              ilace;
        logic              dbl;
        logic              pol_v;
        logic              pol_h;
    } stg_cfg_t;

endpackage

// File: rtl/stg_regfile.sv
module stg_regfile
    import stg_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          frame_end,
    output stg_cfg_t      work,
    output logic          run
);
    localparam int HI = DW / 2;

    typedef struct packed {
        stg_cfg_t shd;
        stg_cfg_t wrk;
        logic     run;
    } rf_t;

    rf_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (addr)
                AW'(ADR_CTRL): begin
                    st_d.run       = wdata[BIT_RUN];
                    st_d.shd.ilace = wdata[BIT_ILACE];
                    st_d.shd.dbl   = wdata[BIT_DOUBLE];
                end
                AW'(ADR_SIZE): begin
                    st_d.shd.va = wdata[HI +: STG_FW];
                    st_d.shd.ha = wdata[0 +: STG_FW];
                end
                AW'(ADR_BACK): begin
                    st_d.shd.vb = wdata[HI +: STG_FW];
                    st_d.shd.hb = wdata[0 +: STG_FW];
                end
                AW'(ADR_FRONT): begin
                    st_d.shd.vf = wdata[HI +: STG_FW];
                    st_d.shd.hf = wdata[0 +: STG_FW];
                end
                AW'(ADR_SYNC): begin
                    st_d.shd.vs = wdata[HI +: STG_FW];
                    st_d.shd.hs = wdata[0 +: STG_FW];
                end
                AW'(ADR_POL): begin
                    st_d.shd.pol_v = wdata[BIT_VPOL];
                    st_d.shd.pol_h = wdata[BIT_HPOL];
                end
                default: ;
            endcase
        end
        if (!st_q.run || frame_end) begin
            st_d.wrk = st_d.shd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign work = st_q.wrk;
    assign run  = st_q.run;

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !frame_end) |=> $stable(st_q.wrk))
        else $error("working timing changed inside a frame");

endmodule

// File: rtl/stg_geom.sv
module stg_geom
    import stg_pkg::*;
#(
    parameter int CW = STG_FW + 2
) (
    input  stg_cfg_t      cfg,
    output logic [CW-1:0] h_act,
    output logic [CW-1:0] h_sstart,
    output logic [CW-1:0] h_send,
    output logic [CW-1:0] h_total,
    output logic [CW-1:0] h_half,
    output logic [CW-1:0] v_act,
    output logic [CW-1:0] v_sstart,
    output logic [CW-1:0] v_send,
    output logic [CW-1:0] v_total
);
    logic [CW-1:0] va_full;
    logic          unused_cfg;

    assign unused_cfg = ^{cfg.dbl, cfg.pol_h, cfg.pol_v};

    always_comb begin
        h_act    = CW'(cfg.ha) + CW'(1);
        h_sstart = CW'(cfg.ha) + CW'(cfg.hf) + CW'(2);
        h_send   = h_sstart + CW'(cfg.hs) + CW'(1);
        h_total  = CW'(cfg.ha) + CW'(cfg.hf) + CW'(cfg.hb) + CW'(3);
        h_half   = h_total >> 1;
        va_full  = CW'(cfg.va) + CW'(1);
        v_act    = cfg.ilace ? (va_full >> 1) : va_full;
        v_sstart = v_act + CW'(cfg.vf) + CW'(1);
        v_send   = v_sstart + CW'(cfg.vs) + CW'(1);
        v_total  = v_act + CW'(cfg.vf) + CW'(cfg.vb) + CW'(2);
    end

endmodule

// File: rtl/stg_counter.sv
module stg_counter #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ilace,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_total,
    output logic [CW-1:0] hc,
    output logic [CW-1:0] vc,
    output logic          fld,
    output logic          frame_end
);
    typedef struct packed {
        logic [CW-1:0] hc;
        logic [CW-1:0] vc;
        logic          fld;
    } cnt_t;

    cnt_t c_q, c_d;
    logic line_end;
    logic field_end;

    always_comb begin
        line_end  = (c_q.hc == h_total - CW'(1));
        field_end = line_end && (c_q.vc == v_total - CW'(1));
        frame_end = run && field_end && (!ilace || c_q.fld);
        c_d = c_q;
        if (!run) begin
            c_d = '0;
        end else if (line_end) begin
            c_d.hc = '0;
            if (field_end) begin
                c_d.vc  = '0;
                c_d.fld = frame_end ? 1'b0 : 1'b1;
            end else begin
                c_d.vc = c_q.vc + CW'(1);
            end
        end else begin
            c_d.hc = c_q.hc + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign hc  = c_q.hc;
    assign vc  = c_q.vc;
    assign fld = c_q.fld;

    p_h_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (c_q.hc < h_total))
        else $error("pixel counter beyond line length");

    p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (c_q.hc == '0 && c_q.vc == '0 && !c_q.fld))
        else $error("frame did not restart at origin");

    p_prog_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ilace |-> !c_q.fld)
        else $error("second field seen in progressive scan");

endmodule

// File: rtl/stg_decode.sv
module stg_decode #(
    parameter int CW = 18,
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ilace,
    input  logic          dbl,
    input  logic          pol_h,
    input  logic          pol_v,
    input  logic [CW-1:0] hc,
    input  logic [CW-1:0] vc,
    input  logic          fld,
    input  logic [CW-1:0] h_act,
    input  logic [CW-1:0] h_sstart,
    input  logic [CW-1:0] h_send,
    input  logic [CW-1:0] h_half,
    input  logic [CW-1:0] v_act,
    input  logic [CW-1:0] v_sstart,
    input  logic [CW-1:0] v_send,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [FW-1:0] px_x,
    output logic [FW-1:0] px_y,
    output logic          field_id
);
    logic hs_act;
    logic vs_act;

    always_comb begin
        hs_act = run && (hc >= h_sstart) && (hc < h_send);
        if (ilace && fld) begin
            vs_act = run && (((vc == v_sstart) && (hc >= h_half)) ||
                             ((vc > v_sstart) && (vc < v_send)) ||
                             ((vc == v_send) && (hc < h_half)));
        end else begin
            vs_act = run && (vc >= v_sstart) && (vc < v_send);
        end
        de       = run && (hc < h_act) && (vc < v_act);
        hsync    = hs_act ~^ pol_h;
        vsync    = vs_act ~^ pol_v;
        px_x     = de ? FW'(dbl ? (hc >> 1) : hc) : '0;
        px_y     = de ? FW'(ilace ? {vc, fld} : {1'b0, vc}) : '0;
        field_id = run && fld;
    end

    p_de_no_hsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> !hs_act)
        else $error("visible strobe overlaps horizontal sync");

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!de && hsync == !pol_h && vsync == !pol_v && px_x == '0))
        else $error("outputs not idle while disabled");

    p_dbl_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (de && dbl && hc[0]) |-> (px_x == $past(px_x)))
        else $error("doubled pixel not held for two clocks");

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import stg_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 32,
    parameter int FW = STG_FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [FW-1:0] px_x,
    output logic [FW-1:0] px_y,
    output logic          field_id
);
    localparam int CW = STG_FW + 2;

    stg_cfg_t      work;
    logic          run;
    logic          frame_end;
    logic [CW-1:0] h_act, h_sstart, h_send, h_total, h_half;
    logic [CW-1:0] v_act, v_sstart, v_send, v_total;
    logic [CW-1:0] hc, vc;
    logic          fld;

    stg_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .frame_end(frame_end), .work(work), .run(run)
    );

    stg_geom #(.CW(CW)) u_geom (
        .cfg(work), .h_act(h_act), .h_sstart(h_sstart), .h_send(h_send),
        .h_total(h_total), .h_half(h_half), .v_act(v_act),
        .v_sstart(v_sstart), .v_send(v_send), .v_total(v_total)
    );

    stg_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .ilace(work.ilace),
        .h_total(h_total), .v_total(v_total), .hc(hc), .vc(vc),
        .fld(fld), .frame_end(frame_end)
    );

    stg_decode #(.CW(CW), .FW(FW)) u_dec (
        .clk(clk), .rst_n(rst_n), .run(run), .ilace(work.ilace),
        .dbl(work.dbl), .pol_h(work.pol_h), .pol_v(work.pol_v),
        .hc(hc), .vc(vc), .fld(fld), .h_act(h_act), .h_sstart(h_sstart),
        .h_send(h_send), .h_half(h_half), .v_act(v_act),
        .v_sstart(v_sstart), .v_send(v_send), .hsync(hsync),
        .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y),
        .field_id(field_id)
    );

endmodule

// File: tb/sim_scan_timing_gen.sv
module sim_scan_timing_gen;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        hsync, vsync, de, field_id;
    logic [15:0] px_x, px_y;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    int mA, mF, mS, mB, mVa, mFv, mSv, mBv;
    bit mIl, mDbl, mPh, mPv;

    always #2.5 clk = ~clk;

    scan_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr),
        .cfg_wdata(wdata), .hsync(hsync), .vsync(vsync), .de(de),
        .px_x(px_x), .px_y(px_y), .field_id(field_id)
    );

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    function automatic logic [31:0] pack2(input int v, input int h);
        return {16'(v - 1), 16'(h - 1)};
    endfunction

    task automatic program_all(input bit en);
        wr(3'd1, pack2(mVa, mA));
        wr(3'd2, pack2(mBv, mB));
        wr(3'd3, pack2(mFv, mF));
        wr(3'd4, pack2(mSv, mS));
        wr(3'd5, {30'b0, mPv, mPh});
        wr(3'd0, {en, 26'b0, mIl, 3'b0, mDbl});
    endtask

    task automatic report(input string tag, input bit ok,
                          input bit ehs, input bit evs, input bit ede,
                          input int ex, input int ey, input bit ef);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual hs=%0b vs=%0b de=%0b x=%0d y=%0d f=%0b expected hs=%0b vs=%0b de=%0b x=%0d y=%0d f=%0b",
                     tag, hsync, vsync, de, px_x, px_y, field_id,
                     ehs, evs, ede, ex, ey, ef);
        end
    endtask

    task automatic chk(input int t, input string tag);
        int H, Vaf, Vt, fl, fr, tt, fld, r, line, x, st, en;
        bit ha, va, d;
        int ex, ey;
        bit ok;
        H   = mA + mF + mB;
        Vaf = mIl ? mVa / 2 : mVa;
        Vt  = Vaf + mFv + mBv;
        fl  = H * Vt;
        fr  = mIl ? 2 * fl : fl;
        tt  = t % fr;
        fld = tt / fl;
        r   = tt % fl;
        line = r / H;
        x   = r % H;
        st  = (Vaf + mFv) * H + (fld != 0 ? H / 2 : 0);
        en  = st + mSv * H;
        ha  = (x >= mA + mF) && (x < mA + mF + mS);
        va  = (r >= st) && (r < en);
        d   = (x < mA) && (line < Vaf);
        ex  = d ? (mDbl ? x / 2 : x) : 0;
        ey  = d ? (mIl ? 2 * line + fld : line) : 0;
        ok  = (hsync == (ha ~^ mPh)) && (vsync == (va ~^ mPv)) && (de == d) &&
              (int'(px_x) == ex) && (int'(px_y) == ey) && (field_id == fld[0]);
        report($sformatf("%s t=%0d", tag, t), ok, ha ~^ mPh, va ~^ mPv, d, ex, ey, fld[0]);
    endtask

    task automatic run_check(input int t0, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(t0 + i, tag);
            @(negedge clk);
        end
    endtask

    task automatic chk_idle(input int n, input string tag);
        bit ok;
        for (int i = 0; i < n; i++) begin
            ok = (hsync == !mPh) && (vsync == !mPv) && !de && px_x == 0 &&
                 px_y == 0 && !field_id;
            report(tag, ok, !mPh, !mPv, 1'b0, 0, 0, 1'b0);
            @(negedge clk);
        end
    endtask

    task automatic set_model(input int a, input int f, input int s, input int b,
                             input int va, input int fv, input int sv, input int bv,
                             input bit il, input bit dbl, input bit ph, input bit pv);
        mA = a; mF = f; mS = s; mB = b;
        mVa = va; mFv = fv; mSv = sv; mBv = bv;
        mIl = il; mDbl = dbl; mPh = ph; mPv = pv;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        set_model(8, 2, 3, 5, 4, 1, 2, 3, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state, polarity fields clear so syncs idle high
        chk_idle(3, "R9 reset idle");

        // R1 R2 R3 R4 R8: progressive, active-high syncs, two frames
        set_model(8, 2, 3, 5, 4, 1, 2, 3, 0, 0, 1, 1);
        program_all(1'b1);
        run_check(0, 290, "R1 R2 R3 R4 R8 progressive");

        // R10: change visible width mid-frame, new width only after frame end
        we = 1'b1; addr = 3'd1; wdata = pack2(4, 6);
        chk(290, "R10 old timing");
        @(negedge clk);
        we = 1'b0;
        run_check(291, 360 - 291, "R10 old timing");
        mA = 6;
        run_check(0, 104, "R10 new timing");

        // R9: disable, idle levels follow polarity; counters rest
        wr(3'd0, 32'd0);
        chk_idle(5, "R9 disabled high-pol");
        mPh = 0; mPv = 0;
        wr(3'd5, 32'd0);
        chk_idle(5, "R9 disabled low-pol");

        // R5 R8: doubled pixels, active-low syncs, restart from origin (R9)
        set_model(16, 4, 6, 10, 4, 1, 2, 3, 0, 1, 0, 0);
        program_all(1'b1);
        run_check(0, 480, "R5 R8 R9 doubled");
        wr(3'd0, 32'd0);

        // R6 R7: interlaced, mixed polarity
        set_model(8, 2, 3, 5, 6, 1, 2, 3, 1, 0, 0, 1);
        program_all(1'b0);
        chk_idle(2, "R8 R9 idle mixed-pol");
        wr(3'd0, {1'b1, 26'b0, 1'b1, 3'b0, 1'b0});
        run_check(0, 420, "R6 R7 interlaced");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule